// File: doc/BRIEF.md
# System Register Store Execution Unit

This unit executes the store-class instructions of a core with 16-bit opcodes. These instructions take a system or control register and either copy it into a general register or push it onto a descending stack in memory. The unit also runs the unconditional software trap. For a trap it hands the trap entry state to the control register file: the return PC, the saved status word and a trap code built from the immediate.

Instructions arrive on a valid/ready issue port. The unit is ready whenever it is not busy, and an instruction is accepted on a clock edge where `issue_valid` and `issue_ready` are both high. While the unit is busy, the issuer must hold the opcode pending.

A push drives a valid/ready memory write port. The unit raises `mem_valid` with the address and data. It keeps all three unchanged until it sees `mem_ready` high at a clock edge. Every cycle of back-pressure extends the instruction by one cycle.

The general register file is read combinationally. The index is taken from the opcode on the issue cycle. Results return as single-cycle write pulses in the cycle after acceptance. Opcodes outside the set below are accepted and do nothing.

Top module: `sysreg_store_unit`

## Requirements
- R1: After reset, `busy`, `mem_valid`, `illegal` and every write pulse are low, and `issue_ready` is high.
- R2: The copy forms 0000nnnn00001010, 0000nnnn00011010 and 0000nnnn00101010 write MACH, MACL and PR respectively into register n. The write is a pulse in the cycle after acceptance. `busy` stays low, so the next instruction can be accepted in that same cycle.
- R3: The push forms are 0100nnnn00110011 (SSR), 0100nnnn01000011 (SPC), 0100nnnn1bbb0011 (bank register bbb), and 0100nnnn00000010, 0100nnnn00010010, 0100nnnn00100010 (MACH, MACL, PR). Each one writes register n with Rn−4, taken modulo 2^32 so that 0 becomes 0xFFFFFFFC. In the cycle after acceptance it also presents a memory write of the source value at that same address.
- R4: The SSR, SPC and bank pushes require `priv_mode`=1. When `priv_mode`=0, the cycle after acceptance shows `illegal` high for one cycle, with no register write, no memory request and `busy` low. The MACH, MACL and PR forms run in either mode.
- R5: `issue_ready` equals the inverse of `busy`. A push keeps `busy` high from the cycle after acceptance until its memory handshake completes, so it occupies at least 2 cycles.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` stay unchanged. Each stalled cycle adds one cycle to the push.
- R7: The trap form 11000011iiiiiiii pulses three writes in the cycle after acceptance: SPC receives PC, SSR receives SR, and TRA receives the immediate shifted left by 2 with every other bit zero. `busy` then stays high for 7 cycles, so the trap occupies 8 cycles.
- R8: Any other opcode is accepted and produces no write, no memory request, no `illegal` pulse and no busy time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Opcode offered |
| issue_ready | output | 1 | Unit can accept an opcode |
| opcode | input | 16 | Instruction word |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| gpr_rd_idx | output | 4 | General register read index (opcode bits 11:8) |
| gpr_rd_data | input | 32 | Read data for `gpr_rd_idx` |
| gpr_wr_en | output | 1 | General register write pulse |
| gpr_wr_idx | output | 4 | General register write index |
| gpr_wr_data | output | 32 | General register write data |
| ssr_i | input | 32 | Saved status register |
| spc_i | input | 32 | Saved PC register |
| bank_i | input | 256 | Eight banked registers, bank k in bits 32k+31:32k |
| mach_i | input | 32 | Multiply-accumulate high |
| macl_i | input | 32 | Multiply-accumulate low |
| pr_i | input | 32 | Procedure return register |
| pc_i | input | 32 | PC of the issued instruction |
| sr_i | input | 32 | Status register |
| spc_wr_en | output | 1 | Saved PC write pulse |
| spc_wr_data | output | 32 | Saved PC write data |
| ssr_wr_en | output | 1 | Saved status write pulse |
| ssr_wr_data | output | 32 | Saved status write data |
| tra_wr_en | output | 1 | Trap code write pulse |
| tra_wr_data | output | 32 | Trap code write data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |
| busy | output | 1 | Unit occupied by a multi-cycle instruction |
| illegal | output | 1 | Privileged form issued in user mode |

## Verification
The bench builds the unit with its defaults: 32-bit data, eight banked registers, a 2-cycle push and an 8-cycle trap. With these values the exact busy windows of both multi-cycle classes can be counted edge by edge. All eight bank selections fall within a random stream of a few hundred instructions. Driving Rn to zero reaches the address wrap to 0xFFFFFFFC. Random stalls of up to three cycles on the memory port stretch pushes past their minimum length.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [1:0] {K_NONE, K_MOVE, K_PUSH, K_TRAP} kind_t;
  typedef enum logic [2:0] {S_SSR, S_SPC, S_BANK, S_MACH, S_MACL, S_PR} src_t;

  typedef struct packed {
    kind_t      kind;
    src_t       src;
    logic       priv;
    logic [2:0] bank;
    logic [3:0] rn;
    logic [7:0] imm;
  } dec_t;

  function automatic src_t sys_src(input logic [3:0] f);
    case (f)
      4'h0:    return S_MACH;
      4'h1:    return S_MACL;
      default: return S_PR;
    endcase
  endfunction

  function automatic dec_t decode(input logic [15:0] op);
    dec_t d;
    d.kind = K_NONE;
    d.src  = S_PR;
    d.priv = 1'b0;
    d.bank = op[6:4];
    d.rn   = op[11:8];
    d.imm  = op[7:0];
    if (op[15:12] == 4'h4 && op[3:0] == 4'h3) begin
      if (op[7]) begin
        d.kind = K_PUSH; d.src = S_BANK; d.priv = 1'b1;
      end else if (op[7:4] == 4'h3) begin
        d.kind = K_PUSH; d.src = S_SSR; d.priv = 1'b1;
      end else if (op[7:4] == 4'h4) begin
        d.kind = K_PUSH; d.src = S_SPC; d.priv = 1'b1;
      end
    end else if (op[15:12] == 4'h4 && op[3:0] == 4'h2 && op[7:4] <= 4'h2) begin
      d.kind = K_PUSH; d.src = sys_src(op[7:4]);
    end else if (op[15:12] == 4'h0 && op[3:0] == 4'hA && op[7:4] <= 4'h2) begin
      d.kind = K_MOVE; d.src = sys_src(op[7:4]);
    end else if (op[15:8] == 8'hC3) begin
      d.kind = K_TRAP;
    end
    return d;
  endfunction
endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  logic [15:0] op,
  output dec_t        dec
);
  always_comb dec = decode(op);
endmodule

// File: rtl/sru_bank_mux.sv
module sru_bank_mux #(
  parameter int W  = 32,
  parameter int NB = 8,
  localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB*W-1:0] flat,
  input  logic [SW-1:0]   sel,
  output logic [W-1:0]    q
);
  logic [W-1:0] slot [NB];
  for (genvar k = 0; k < NB; k++) begin : g_unpack
    assign slot[k] = flat[k*W +: W];
  end
  always_comb begin
    q = '0;
    for (int k = 0; k < NB; k++)
      if (SW'(k) == sel) q = slot[k];
  end
endmodule

// File: rtl/sru_seq.sv
module sru_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_cnt,
  input  logic          start_mem,
  input  logic          mem_ready,
  output logic          busy,
  output logic          mem_valid
);
  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (start) begin
      cnt  <= start_cnt;
      pend <= start_mem;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (pend && mem_ready) pend <= 1'b0;
    end
  end

  assign busy      = (cnt != '0) || pend;
  assign mem_valid = pend;
endmodule

// File: rtl/sysreg_store_unit.sv
module sysreg_store_unit
  import sru_pkg::*;
#(
  parameter int W           = 32,
  parameter int NBANK       = 8,
  parameter int PUSH_CYCLES = 2,
  parameter int TRAP_CYCLES = 8,
  parameter int STEP        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  output logic             issue_ready,
  input  logic [15:0]      opcode,
  input  logic             priv_mode,
  output logic [3:0]       gpr_rd_idx,
  input  logic [W-1:0]     gpr_rd_data,
  output logic             gpr_wr_en,
  output logic [3:0]       gpr_wr_idx,
  output logic [W-1:0]     gpr_wr_data,
  input  logic [W-1:0]     ssr_i,
  input  logic [W-1:0]     spc_i,
  input  logic [NBANK*W-1:0] bank_i,
  input  logic [W-1:0]     mach_i,
  input  logic [W-1:0]     macl_i,
  input  logic [W-1:0]     pr_i,
  input  logic [W-1:0]     pc_i,
  input  logic [W-1:0]     sr_i,
  output logic             spc_wr_en,
  output logic [W-1:0]     spc_wr_data,
  output logic             ssr_wr_en,
  output logic [W-1:0]     ssr_wr_data,
  output logic             tra_wr_en,
  output logic [W-1:0]     tra_wr_data,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_data,
  output logic             busy,
  output logic             illegal
);
  localparam int MAXC = (TRAP_CYCLES > PUSH_CYCLES) ? TRAP_CYCLES : PUSH_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BSW  = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [CW-1:0] PUSH_CNT = CW'(PUSH_CYCLES - 1);
  localparam logic [CW-1:0] TRAP_CNT = CW'(TRAP_CYCLES - 1);

  dec_t         dec;
  logic [W-1:0] bank_q, src_val, dec_addr;
  logic         accept, viol, go;
  logic [CW-1:0] start_cnt;

  sru_decode u_dec (.op(opcode), .dec(dec));

  sru_bank_mux #(.W(W), .NB(NBANK)) u_bank (
    .flat(bank_i), .sel(dec.bank[BSW-1:0]), .q(bank_q));

  assign issue_ready = !busy;
  assign accept      = issue_valid && issue_ready;
  assign viol        = dec.priv && !priv_mode;
  assign go          = accept && (dec.kind != K_NONE) && !viol;
  assign gpr_rd_idx  = dec.rn;
  assign dec_addr    = gpr_rd_data - W'(STEP);

  always_comb begin
    case (dec.src)
      S_SSR:   src_val = ssr_i;
      S_SPC:   src_val = spc_i;
      S_BANK:  src_val = bank_q;
      S_MACH:  src_val = mach_i;
      S_MACL:  src_val = macl_i;
      default: src_val = pr_i;
    endcase
  end

  always_comb begin
    case (dec.kind)
      K_PUSH:  start_cnt = PUSH_CNT;
      K_TRAP:  start_cnt = TRAP_CNT;
      default: start_cnt = '0;
    endcase
  end

  sru_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go), .start_cnt(start_cnt),
    .start_mem(dec.kind == K_PUSH), .mem_ready(mem_ready),
    .busy(busy), .mem_valid(mem_valid));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpr_wr_en   <= 1'b0;
      gpr_wr_idx  <= '0;
      gpr_wr_data <= '0;
      spc_wr_en   <= 1'b0;
      spc_wr_data <= '0;
      ssr_wr_en   <= 1'b0;
      ssr_wr_data <= '0;
      tra_wr_en   <= 1'b0;
      tra_wr_data <= '0;
      mem_addr    <= '0;
      mem_data    <= '0;
      illegal     <= 1'b0;
    end else begin
      gpr_wr_en <= 1'b0;
      spc_wr_en <= 1'b0;
      ssr_wr_en <= 1'b0;
      tra_wr_en <= 1'b0;
      illegal   <= accept && viol;
      if (go) begin
        case (dec.kind)
          K_MOVE: begin
            gpr_wr_en   <= 1'b1;
            gpr_wr_idx  <= dec.rn;
            gpr_wr_data <= src_val;
          end
          K_PUSH: begin
            gpr_wr_en   <= 1'b1;
            gpr_wr_idx  <= dec.rn;
            gpr_wr_data <= dec_addr;
            mem_addr    <= dec_addr;
            mem_data    <= src_val;
          end
          K_TRAP: begin
            spc_wr_en   <= 1'b1;
            spc_wr_data <= pc_i;
            ssr_wr_en   <= 1'b1;
            ssr_wr_data <= sr_i;
            tra_wr_en   <= 1'b1;
            tra_wr_data <= {{(W-10){1'b0}}, dec.imm, 2'b00};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue_valid,
  input logic         issue_ready,
  input logic [15:0]  opcode,
  input logic         busy,
  input logic         illegal,
  input logic         gpr_wr_en,
  input logic [W-1:0] gpr_wr_data,
  input logic         spc_wr_en,
  input logic         ssr_wr_en,
  input logic         tra_wr_en,
  input logic [W-1:0] tra_wr_data,
  input logic         mem_valid,
  input logic         mem_ready,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_data
);
  // R6: request held steady under back-pressure
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R3: new request comes with the matching pre-decremented register write
  p_push_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> gpr_wr_en && (gpr_wr_data == mem_addr));

  // R4: a user-mode violation touches nothing
  p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !gpr_wr_en && !mem_valid && !spc_wr_en && !tra_wr_en && !busy);

  // R7: trap writes come together and the trap code has its fixed shape
  p_tra_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tra_wr_en |-> spc_wr_en && ssr_wr_en && (tra_wr_data[1:0] == 2'b00)
                  && (tra_wr_data[W-1:10] == '0));

  // R7: an accepted trap makes the unit busy
  p_trap_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready && (opcode[15:8] == 8'hC3) |=> busy);

  // R5: no acceptance while busy
  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !issue_ready);
endmodule

bind sysreg_store_unit sru_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
  .opcode(opcode), .busy(busy), .illegal(illegal), .gpr_wr_en(gpr_wr_en),
  .gpr_wr_data(gpr_wr_data), .spc_wr_en(spc_wr_en), .ssr_wr_en(ssr_wr_en),
  .tra_wr_en(tra_wr_en), .tra_wr_data(tra_wr_data), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data));

// File: tb/sysreg_store_unit_tb_top.sv
module sysreg_store_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        issue_valid = 1'b0, priv_mode = 1'b0, mem_ready = 1'b0;
  logic [15:0] opcode = '0;
  logic        issue_ready, gpr_wr_en, spc_wr_en, ssr_wr_en, tra_wr_en;
  logic        mem_valid, busy, illegal;
  logic [3:0]  gpr_rd_idx, gpr_wr_idx;
  logic [31:0] gpr_rd_data, gpr_wr_data, spc_wr_data, ssr_wr_data, tra_wr_data;
  logic [31:0] mem_addr, mem_data;
  logic [31:0] ssr_v = '0, spc_v = '0, mach_v = '0, macl_v = '0, pr_v = '0;
  logic [31:0] pc_v = '0, sr_v = '0;
  logic [31:0] bank_m [8];
  logic [255:0] bank_flat;
  logic [31:0] gpr [16];

  always_comb for (int k = 0; k < 8; k++) bank_flat[k*32 +: 32] = bank_m[k];
  assign gpr_rd_data = gpr[gpr_rd_idx];

  sysreg_store_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .opcode(opcode), .priv_mode(priv_mode), .gpr_rd_idx(gpr_rd_idx),
    .gpr_rd_data(gpr_rd_data), .gpr_wr_en(gpr_wr_en), .gpr_wr_idx(gpr_wr_idx),
    .gpr_wr_data(gpr_wr_data), .ssr_i(ssr_v), .spc_i(spc_v), .bank_i(bank_flat),
    .mach_i(mach_v), .macl_i(macl_v), .pr_i(pr_v), .pc_i(pc_v), .sr_i(sr_v),
    .spc_wr_en(spc_wr_en), .spc_wr_data(spc_wr_data), .ssr_wr_en(ssr_wr_en),
    .ssr_wr_data(ssr_wr_data), .tra_wr_en(tra_wr_en), .tra_wr_data(tra_wr_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .illegal(illegal));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // bench decode: 0 none, 1 move, 2 push, 3 trap
  task automatic bdec(input logic [15:0] op, output int kind, output bit priv,
                      output logic [31:0] val);
    logic [31:0] sys3 [3];
    sys3[0] = mach_v; sys3[1] = macl_v; sys3[2] = pr_v;
    kind = 0; priv = 0; val = '0;
    if (op[15:12] == 4'h4 && op[3:0] == 4'h3) begin
      if (op[7]) begin kind = 2; priv = 1; val = bank_m[op[6:4]]; end
      else if (op[7:4] == 4'h3) begin kind = 2; priv = 1; val = ssr_v; end
      else if (op[7:4] == 4'h4) begin kind = 2; priv = 1; val = spc_v; end
    end else if (op[15:12] == 4'h4 && op[3:0] == 4'h2 && op[7:4] < 3) begin
      kind = 2; val = sys3[op[5:4]];
    end else if (op[15:12] == 4'h0 && op[3:0] == 4'hA && op[7:4] < 3) begin
      kind = 1; val = sys3[op[5:4]];
    end else if (op[15:8] == 8'hC3) kind = 3;
  endtask

  task automatic shuffle_ctrl();
    ssr_v = $urandom; spc_v = $urandom; mach_v = $urandom; macl_v = $urandom;
    pr_v = $urandom; pc_v = $urandom; sr_v = $urandom;
    for (int k = 0; k < 8; k++) bank_m[k] = $urandom;
  endtask

  task automatic run_op(input logic [15:0] op, input logic pm);
    int kind; bit priv; logic [31:0] val, na;
    int n, stalls;
    n = op[11:8];
    @(negedge clk);
    shuffle_ctrl();
    bdec(op, kind, priv, val);
    na = gpr[n] - 32'd4;
    chk("R5 ready when idle", {31'b0, issue_ready}, 32'd1);
    opcode = op; priv_mode = pm; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    if (kind != 0 && priv && !pm) begin
      chk("R4 illegal pulse", {31'b0, illegal}, 32'd1);
      chk("R4 no writes", {29'b0, gpr_wr_en, mem_valid, busy}, 32'd0);
      @(negedge clk);
      chk("R4 illegal one cycle", {31'b0, illegal}, 32'd0);
    end else if (kind == 1) begin
      chk("R2 wr_en", {31'b0, gpr_wr_en}, 32'd1);
      chk("R2 wr_idx", {28'b0, gpr_wr_idx}, n);
      chk("R2 wr_data", gpr_wr_data, val);
      chk("R2 not busy", {30'b0, busy, mem_valid}, 32'd0);
      gpr[n] = val;
    end else if (kind == 2) begin
      chk("R3 wr_en", {31'b0, gpr_wr_en}, 32'd1);
      chk("R3 wr_idx", {28'b0, gpr_wr_idx}, n);
      chk("R3 Rn-4", gpr_wr_data, na);
      chk("R3 mem_valid", {31'b0, mem_valid}, 32'd1);
      chk("R3 mem_addr", mem_addr, na);
      chk("R3 mem_data", mem_data, val);
      chk("R5 busy", {31'b0, busy}, 32'd1);
      gpr[n] = na;
      stalls = $urandom_range(0, 3);
      for (int s = 0; s < stalls; s++) begin
        @(negedge clk);
        chk("R6 held valid", {30'b0, mem_valid, busy}, 32'd3);
        chk("R6 held addr", mem_addr, na);
        chk("R6 held data", mem_data, val);
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      chk("R5 done after handshake", {30'b0, mem_valid, busy}, 32'd0);
    end else if (kind == 3) begin
      chk("R7 pulses", {29'b0, spc_wr_en, ssr_wr_en, tra_wr_en}, 32'd7);
      chk("R7 spc", spc_wr_data, pc_v);
      chk("R7 ssr", ssr_wr_data, sr_v);
      chk("R7 tra", tra_wr_data, {22'b0, op[7:0], 2'b00});
      chk("R7 busy", {31'b0, busy}, 32'd1);
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        chk("R7 busy window", {31'b0, busy}, 32'd1);
      end
      @(negedge clk);
      chk("R7 trap ends", {31'b0, busy}, 32'd0);
    end else begin
      chk("R8 no effect", {26'b0, gpr_wr_en, mem_valid, busy, illegal, spc_wr_en, tra_wr_en},
          32'd0);
    end
  endtask

  function automatic logic [15:0] rand_op();
    logic [3:0] n = 4'($urandom);
    case ($urandom_range(0, 5))
      0: return {4'h0, n, 2'b00, 2'($urandom_range(0, 2)), 4'hA};
      1: return {4'h4, n, 2'b00, 2'($urandom_range(0, 2)), 4'h2};
      2: return {4'h4, n, ($urandom_range(0, 1) != 0) ? 4'h3 : 4'h4, 4'h3};
      3: return {4'h4, n, 1'b1, 3'($urandom), 4'h3};
      4: return {8'hC3, 8'($urandom)};
      default: return {4'hE, 12'($urandom)};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 16; k++) gpr[k] = {$urandom} & 32'hFFFF_FFFC;
    for (int k = 0; k < 8; k++) bank_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset idle", {26'b0, busy, mem_valid, illegal, gpr_wr_en, spc_wr_en, tra_wr_en},
        32'd0);
    chk("R1 reset ready", {31'b0, issue_ready}, 32'd1);
    // directed corners
    gpr[5] = 32'd0;
    run_op(16'h4502, 1'b0);   // R3 MACH push in user mode, wrap at zero
    chk("R3 wrap", gpr[5], 32'hFFFF_FFFC);
    run_op(16'h4383, 1'b0);   // R4 bank push in user mode
    run_op(16'h43F3, 1'b1);   // R3 bank 7 push
    run_op(16'h012A, 1'b0);   // R2 PR copy
    run_op(16'hC3FF, 1'b0);   // R7 trap with all-ones immediate
    run_op(16'h0009, 1'b1);   // R8 unrecognized
    for (int i = 0; i < 400; i++) run_op(rand_op(), 1'($urandom));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule